// File: doc/BRIEF.md
# Raster Test Pattern Generator

This block sits in a display pipe behind a timing generator and, when enabled, replaces the incoming video with a synthetic pattern derived from the raster counters. It can draw vertical bars, horizontal bars, or a gray ramp at 6, 8 or 10 bits per component. With the mode set to off, the incoming video passes through unchanged.

Bar colors come from six 16-bit component registers: red, green and blue of color set 0 and of color set 1. Software loads them through one write port that carries a one-hot component mask and a data word. The mask of a write chooses where the data of the next write lands. Loading all six components therefore takes seven writes. Each stored value is left-aligned. The output is reduced to the selected depth by a right shift and placed right-aligned in a 10-bit field per component. The output is registered one cycle after the inputs.

Top module: `test_pattern_gen`

## Requirements
- R1: While `rst_n` is low, the pixel output is zero on the next cycle. Reset clears all six components and the pending mask, so a bar pattern drawn after reset is all zero.
- R2: A write stores its data into the component chosen by the mask of the previous write. Mask bit 0 selects R0, bit 1 G0, bit 2 B0, bit 3 R1, bit 4 G1 and bit 5 B1. The first write after reset stores nothing.
- R3: Only data bits 15:6 are kept. Bits 5:0 of a write have no effect on any output.
- R4: The depth code selects the output depth D: 0 gives 6 bits, 1 gives 8, 2 gives 10, and 3 falls back to 8. A 16-bit value v appears on the output as v >> (16 - D), right-aligned in a 10-bit field. The output is packed as {R, G, B}.
- R5: Mode 1 draws vertical bars. Bit `hres_exp` of `hcount` selects color set 1 when it is set and color set 0 when it is clear.
- R6: Mode 2 draws horizontal bars. Bit `vres_exp` of `vcount` selects the color set.
- R7: In mode 3 at depths 6 and 8, all three components show the single ramp (hcount << (16 - D)) mod 2^16, reduced as in R4.
- R8: In mode 3 at depth 10, lines where bit `vres_exp` of `vcount` is clear show the first ramp, hcount << 6. The other lines show the second ramp, 24576 + (hcount << 8) mod 2^16, which is an offset of 384 in 10-bit units.
- R9: In mode 0 the output equals `vid_in`, whatever the value of `active`.
- R10: In modes 1 to 3 the output is zero when `active` is low.
- R11: The output reflects the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hcount | input | 12 | Horizontal raster position |
| vcount | input | 12 | Vertical raster position |
| active | input | 1 | High inside the active picture |
| mode | input | 2 | 0 off, 1 vertical bars, 2 horizontal bars, 3 ramp |
| depth | input | 2 | Output depth code (see R4) |
| hres_exp | input | 4 | Log2 of the vertical bar width in pixels |
| vres_exp | input | 4 | Log2 of the bar height and the ramp band height in lines |
| wr_en | input | 1 | Color port write strobe |
| wr_mask | input | 6 | One-hot component mask for the next write |
| wr_data | input | 16 | Left-aligned component data |
| vid_in | input | 30 | Pass-through video {R, G, B} |
| pix_out | output | 30 | Output pixel {R, G, B}, 10 bits per component |

## Verification
The bench builds the block with its default parameters: 12-bit counters, 4-bit bar exponents, six components and a 10-bit output field. With 12-bit counters, every bar exponent from 0 to 11 can be reached, and so can ramp values that wrap past 2^16 at each depth, including the shifted second ramp. Random mixes of mode, depth, position and bar size run against colors reloaded through the one-hot port. Directed cases cover the first write after reset, the low data bits, the fallback depth code, and blanking.

// File: rtl/tpg_pkg.sv
// Shared types and helpers for the test pattern generator.
// Assumes the depth code is 2 bits and a 16-bit source component.
package tpg_pkg;
    typedef enum logic [1:0] {
        TP_OFF  = 2'd0,
        TP_VBAR = 2'd1,
        TP_HBAR = 2'd2,
        TP_RAMP = 2'd3
    } tp_mode_e;

    localparam int SRC_W = 16;

    // Right shift that reduces a 16-bit source to the coded depth
    function automatic logic [4:0] depth_shift(input logic [1:0] code);
        case (code)
            2'd0:    return 5'd10;
            2'd2:    return 5'd6;
            default: return 5'd8;
        endcase
    endfunction
endpackage

// File: rtl/tpg_color_regs.sv
// Six bar-color components loaded through a mask-plus-data port.
// A write stores its data into the components selected by the mask of the
// previous write, then remembers its own mask. Only the upper bits of the
// data are kept; the low ZERO_LSB bits read as zero.
module tpg_color_regs #(
    parameter int NCOMP    = 6,
    parameter int DATA_W   = 16,
    parameter int ZERO_LSB = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [NCOMP-1:0]  wr_mask,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] comps [NCOMP],
    output logic [NCOMP-1:0]  pend_mask
);
    localparam int KEEP_W = DATA_W - ZERO_LSB;

    // Pending mask: remembers where the next data word goes
    always_ff @(posedge clk) begin
        if (!rst_n)     pend_mask <= '0;
        else if (wr_en) pend_mask <= wr_mask;
    end

    for (genvar i = 0; i < NCOMP; i++) begin : g_comp
        logic [KEEP_W-1:0] kept;
        // Component storage: only the significant upper bits
        always_ff @(posedge clk) begin
            if (!rst_n)                    kept <= '0;
            else if (wr_en && pend_mask[i]) kept <= wr_data[DATA_W-1:ZERO_LSB];
        end
        assign comps[i] = {kept, {ZERO_LSB{1'b0}}};
    end
endmodule

// File: rtl/tpg_bar_select.sv
// Picks color set 0 or 1 from the raster position.
// Vertical bars toggle on hcount bit hres; horizontal bars on vcount bit vres.
module tpg_bar_select #(
    parameter int CNT_W = 12,
    parameter int EXP_W = 4
) (
    input  logic [CNT_W-1:0] hcount,
    input  logic [CNT_W-1:0] vcount,
    input  logic [EXP_W-1:0] hres_exp,
    input  logic [EXP_W-1:0] vres_exp,
    input  logic             vertical,
    output logic             set_sel
);
    logic [CNT_W-1:0] h_sh, v_sh;

    // Shift the chosen bit down to position 0
    always_comb begin
        h_sh    = hcount >> hres_exp;
        v_sh    = vcount >> vres_exp;
        set_sel = vertical ? h_sh[0] : v_sh[0];
    end
endmodule

// File: rtl/tpg_ramp.sv
// Gray ramp in 16-bit source units.
// Single ramp: hcount << shift. In dual mode, lines with vcount bit vres set
// take the second ramp, whose step is four times larger and which starts at RAMP_OFS.
module tpg_ramp #(
    parameter int CNT_W    = 12,
    parameter int EXP_W    = 4,
    parameter int DATA_W   = 16,
    parameter int RAMP_OFS = 384 << 6
) (
    input  logic [CNT_W-1:0]  hcount,
    input  logic [CNT_W-1:0]  vcount,
    input  logic [EXP_W-1:0]  vres_exp,
    input  logic [4:0]        shift,
    input  logic              dual,
    output logic [DATA_W-1:0] ramp_val
);
    localparam logic [DATA_W-1:0] OFS = DATA_W'(RAMP_OFS);

    logic [DATA_W-1:0] h_ext, first, second;
    logic [CNT_W-1:0]  v_sh;

    // Build both ramps and choose by line band
    always_comb begin
        h_ext    = DATA_W'(hcount);
        first    = h_ext << shift;
        second   = OFS + (h_ext << (shift + 5'd2));
        v_sh     = vcount >> vres_exp;
        ramp_val = (dual && v_sh[0]) ? second : first;
    end
endmodule

// File: rtl/test_pattern_gen.sv
// Test pattern generator top. Replaces video with bars or a gray ramp driven
// by the raster counters; mode off passes vid_in. Output registered once.
// Assumes depth codes per tpg_pkg::depth_shift and one-hot color writes.
module test_pattern_gen
    import tpg_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int EXP_W  = 4,
    parameter int COMP_W = 10,
    parameter int NCOMP  = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CNT_W-1:0]    hcount,
    input  logic [CNT_W-1:0]    vcount,
    input  logic                active,
    input  logic [1:0]          mode,
    input  logic [1:0]          depth,
    input  logic [EXP_W-1:0]    hres_exp,
    input  logic [EXP_W-1:0]    vres_exp,
    input  logic                wr_en,
    input  logic [NCOMP-1:0]    wr_mask,
    input  logic [SRC_W-1:0]    wr_data,
    input  logic [3*COMP_W-1:0] vid_in,
    output logic [3*COMP_W-1:0] pix_out
);
    localparam int ZERO_LSB = SRC_W - COMP_W;
    localparam int SET_STEP = NCOMP / 2;

    logic [SRC_W-1:0]    comps [NCOMP];
    logic [NCOMP-1:0]    pend_mask;
    logic                set_sel;
    logic [SRC_W-1:0]    ramp_val;
    logic [4:0]          shift;
    logic [3*COMP_W-1:0] pix_nxt;
    tp_mode_e            mode_e;

    tpg_color_regs #(.NCOMP(NCOMP), .DATA_W(SRC_W), .ZERO_LSB(ZERO_LSB)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mask(wr_mask),
        .wr_data(wr_data), .comps(comps), .pend_mask(pend_mask)
    );

    tpg_bar_select #(.CNT_W(CNT_W), .EXP_W(EXP_W)) u_bar (
        .hcount(hcount), .vcount(vcount), .hres_exp(hres_exp),
        .vres_exp(vres_exp), .vertical(mode_e == TP_VBAR), .set_sel(set_sel)
    );

    tpg_ramp #(.CNT_W(CNT_W), .EXP_W(EXP_W), .DATA_W(SRC_W)) u_ramp (
        .hcount(hcount), .vcount(vcount), .vres_exp(vres_exp),
        .shift(shift), .dual(depth == 2'd2), .ramp_val(ramp_val)
    );

    // Reduce a left-aligned source value to the selected depth
    function automatic logic [COMP_W-1:0] reduce(input logic [SRC_W-1:0] v,
                                                 input logic [4:0] sh);
        logic [SRC_W-1:0] t;
        t = v >> sh;
        return t[COMP_W-1:0];
    endfunction

    // Decode mode and depth
    always_comb begin
        mode_e = tp_mode_e'(mode);
        shift  = depth_shift(depth);
    end

    // Choose the next pixel by mode
    always_comb begin
        pix_nxt = '0;
        if (mode_e == TP_OFF) begin
            pix_nxt = vid_in;
        end else if (active) begin
            if (mode_e == TP_RAMP) begin
                pix_nxt = {3{reduce(ramp_val, shift)}};
            end else if (set_sel) begin
                pix_nxt = {reduce(comps[SET_STEP], shift),
                           reduce(comps[SET_STEP+1], shift),
                           reduce(comps[SET_STEP+2], shift)};
            end else begin
                pix_nxt = {reduce(comps[0], shift),
                           reduce(comps[1], shift),
                           reduce(comps[2], shift)};
            end
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) pix_out <= '0;
        else        pix_out <= pix_nxt;
    end
endmodule

// File: rtl/tpg_checker.sv
// Timing properties of the test pattern generator, bound to the top.
module tpg_checker #(
    parameter int NCOMP  = 6,
    parameter int COMP_W = 10
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          mode,
    input logic                active,
    input logic [3*COMP_W-1:0] vid_in,
    input logic                wr_en,
    input logic [NCOMP-1:0]    wr_mask,
    input logic [NCOMP-1:0]    pend_mask,
    input logic [3*COMP_W-1:0] pix_out
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) !rst_n |=> pix_out == '0);

    // R2
    pend_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $onehot(wr_mask)) |=> pend_mask == $past(wr_mask));

    // R9
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0) |=> pix_out == $past(vid_in));

    // R10
    blank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'd0 && !active) |=> pix_out == '0);

    // R7
    ramp_gray_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3 && active) |=>
        (pix_out[3*COMP_W-1:2*COMP_W] == pix_out[2*COMP_W-1:COMP_W] &&
         pix_out[2*COMP_W-1:COMP_W] == pix_out[COMP_W-1:0]));
endmodule

bind test_pattern_gen tpg_checker #(.NCOMP(NCOMP), .COMP_W(COMP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .active(active), .vid_in(vid_in),
    .wr_en(wr_en), .wr_mask(wr_mask), .pend_mask(pend_mask), .pix_out(pix_out)
);

// File: tb/tb_test_pattern_gen.sv
module tb_test_pattern_gen;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] hcount = '0, vcount = '0;
    logic        active = 1'b0;
    logic [1:0]  mode = '0, depth = '0;
    logic [3:0]  hres_exp = '0, vres_exp = '0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_mask = '0;
    logic [15:0] wr_data = '0;
    logic [29:0] vid_in = '0;
    logic [29:0] pix_out;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    logic [15:0] m_comp [6];
    logic [5:0]  m_pend;

    always #(CLK_PERIOD/2) clk = ~clk;

    test_pattern_gen dut (
        .clk(clk), .rst_n(rst_n), .hcount(hcount), .vcount(vcount),
        .active(active), .mode(mode), .depth(depth), .hres_exp(hres_exp),
        .vres_exp(vres_exp), .wr_en(wr_en), .wr_mask(wr_mask),
        .wr_data(wr_data), .vid_in(vid_in), .pix_out(pix_out)
    );

    function automatic int dsh(input logic [1:0] d);
        return (d == 2'd0) ? 10 : (d == 2'd2) ? 6 : 8;
    endfunction

    function automatic logic [9:0] red(input logic [15:0] v, input int sh);
        logic [15:0] t;
        t = v >> sh;
        return t[9:0];
    endfunction

    function automatic logic [29:0] expect_pix(
        input logic [1:0] md, input logic [1:0] dp, input logic act,
        input logic [11:0] h, input logic [11:0] v,
        input logic [3:0] hr, input logic [3:0] vr, input logic [29:0] vid);
        int sh;
        int b;
        logic [15:0] h16, rv;
        logic [11:0] hs, vs;
        sh = dsh(dp);
        hs = h >> hr;
        vs = v >> vr;
        if (md == 2'd0) return vid;
        if (!act) return '0;
        if (md == 2'd3) begin
            h16 = 16'(h);
            if (dp == 2'd2 && vs[0]) rv = 16'd24576 + (h16 << (sh + 2));
            else                     rv = h16 << sh;
            return {3{red(rv, sh)}};
        end
        b = ((md == 2'd1) ? hs[0] : vs[0]) ? 3 : 0;
        return {red(m_comp[b], sh), red(m_comp[b+1], sh), red(m_comp[b+2], sh)};
    endfunction

    task automatic do_write(input logic [5:0] m, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_mask = m; wr_data = d;
        for (int i = 0; i < 6; i++)
            if (m_pend[i]) m_comp[i] = {d[15:6], 6'b0};
        m_pend = m;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_all(input logic [15:0] c [6]);
        do_write(6'b000001, 16'h0000);
        for (int i = 0; i < 6; i++)
            do_write((i < 5) ? 6'(1 << (i + 1)) : 6'b100000, c[i]);
    endtask

    task automatic pix_check(input string req, input logic [1:0] md,
        input logic [1:0] dp, input logic act, input logic [11:0] h,
        input logic [11:0] v, input logic [3:0] hr, input logic [3:0] vr,
        input logic [29:0] vid);
        logic [29:0] e;
        @(negedge clk);
        mode = md; depth = dp; active = act; hcount = h; vcount = v;
        hres_exp = hr; vres_exp = vr; vid_in = vid;
        e = expect_pix(md, dp, act, h, v, hr, vr, vid);
        @(negedge clk);
        checks++;
        if (pix_out !== e) begin
            errors++;
            $display("FAIL %s: got %h expected %h (mode %0d depth %0d h %0d v %0d)",
                     req, pix_out, e, md, dp, h, v);
        end
    endtask

    initial begin
        repeat (CLK_PERIOD * 200000) #1;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] cols [6];
        process::self().srandom(32'd2024);
        for (int i = 0; i < 6; i++) m_comp[i] = '0;
        m_pend = '0;
        repeat (3) @(negedge clk);
        checks++;
        if (pix_out !== '0) begin
            errors++;
            $display("FAIL R1: got %h expected 0", pix_out);
        end
        rst_n = 1'b1;
        // R1: components clear after reset, both color sets
        pix_check("R1", 2'd1, 2'd2, 1'b1, 12'd0, 12'd0, 4'd2, 4'd0, '0);
        pix_check("R1", 2'd1, 2'd2, 1'b1, 12'd4, 12'd0, 4'd2, 4'd0, '0);
        // R2: first write stores nothing, second lands in R0
        do_write(6'b000001, 16'hFFFF);
        pix_check("R2", 2'd1, 2'd2, 1'b1, 12'd0, 12'd0, 4'd2, 4'd0, '0);
        do_write(6'b000010, 16'hABC0);
        pix_check("R2", 2'd1, 2'd2, 1'b1, 12'd0, 12'd0, 4'd2, 4'd0, '0);
        // R3: low six data bits ignored
        do_write(6'b000100, 16'h123F);
        pix_check("R3", 2'd1, 2'd2, 1'b1, 12'd0, 12'd0, 4'd2, 4'd0, '0);
        // R2: seven-write load of distinct colors
        cols[0] = 16'hF800; cols[1] = 16'h07C0; cols[2] = 16'h5540;
        cols[3] = 16'h0FC0; cols[4] = 16'hA000; cols[5] = 16'hFFC0;
        load_all(cols);
        for (int d = 0; d < 4; d++) begin
            // R4: each depth code including the fallback
            pix_check("R4", 2'd1, 2'(d), 1'b1, 12'd3, 12'd0, 4'd2, 4'd0, '0);
            pix_check("R4", 2'd1, 2'(d), 1'b1, 12'd5, 12'd0, 4'd2, 4'd0, '0);
        end
        // R5 / R6 bar edges
        pix_check("R5", 2'd1, 2'd1, 1'b1, 12'd2047, 12'd0, 4'd11, 4'd0, '0);
        pix_check("R5", 2'd1, 2'd1, 1'b1, 12'd2048, 12'd0, 4'd11, 4'd0, '0);
        pix_check("R6", 2'd2, 2'd2, 1'b1, 12'd0, 12'd7, 4'd0, 4'd3, '0);
        pix_check("R6", 2'd2, 2'd2, 1'b1, 12'd0, 12'd8, 4'd0, 4'd3, '0);
        // R7 / R8 ramps with wrap
        pix_check("R7", 2'd3, 2'd0, 1'b1, 12'd70, 12'd0, 4'd0, 4'd0, '0);
        pix_check("R7", 2'd3, 2'd1, 1'b1, 12'd300, 12'd0, 4'd0, 4'd0, '0);
        pix_check("R8", 2'd3, 2'd2, 1'b1, 12'd1023, 12'd0, 4'd0, 4'd1, '0);
        pix_check("R8", 2'd3, 2'd2, 1'b1, 12'd700, 12'd2, 4'd0, 4'd1, '0);
        // R9 / R10
        pix_check("R9", 2'd0, 2'd1, 1'b0, 12'd1, 12'd1, 4'd0, 4'd0, 30'h2AAAAAAA);
        pix_check("R10", 2'd2, 2'd1, 1'b0, 12'd1, 12'd1, 4'd0, 4'd0, 30'h3FFFFFFF);
        // R11: back-to-back changes each seen one cycle later
        for (int k = 0; k < 4; k++)
            pix_check("R11", 2'(k), 2'd2, 1'b1, 12'(k * 9), 12'(k), 4'd1, 4'd1, 30'(k * 77));
        // Random mix with periodic color reloads
        for (int n = 0; n < 400; n++) begin
            if (n % 50 == 0) begin
                for (int i = 0; i < 6; i++) cols[i] = 16'($urandom);
                load_all(cols);
            end
            pix_check("R5/R6/R7/R8/R9/R10 random", 2'($urandom), 2'($urandom),
                      1'($urandom), 12'($urandom), 12'($urandom),
                      4'($urandom % 12), 4'($urandom % 12), 30'($urandom));
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule